// File: doc/BRIEF.md
# Serial Flash Register Command Engine

This block sits behind a word-addressed control/status slave and turns single register accesses into complete command frames for a serial NOR flash on a single-lane SPI link. Each register offset names one flash operation. A write to an offset sends that operation's opcode and, where it has one, an operand. A read from an offset sends the opcode, clocks in the flash's reply and returns it as read data. The requester holds its strobe while the frame is on the wire. The slave keeps waitrequest high until the frame has finished, and then completes the access. A read is answered one cycle later with read-data-valid.

A local control register chooses which of several flash chips gets the chip select. It can also release the link pins so that other masters can share the bus. The engine tracks whether the flash has been switched to 4-byte addressing, and sizes erase addresses to match.

Top module: `sfc_cmd_engine`

## Requirements
- R1: While an access that starts a flash command is held, `csr_wait` stays high for at least two clocks per transferred bit. It falls once the frame has ended. `csr_rvalid` pulses exactly in the cycle after an accepted read, and `csr_rdata` is valid in that cycle. An accepted write never raises `csr_rvalid`.
- R2: The offset-to-opcode mapping is as follows. Writes: 0→06h, 1→04h, 2→01h, 4→D8h, 5→20h, 13→B1h, 16→50h, 17→C7h, 18→C4h, 19→B7h, 20→E9h, 21→01h. Reads: 3→05h, 14→B5h, 15→70h, 22→9Fh.
- R3: Writes to offsets 0, 1, 17, 18, 19 and 20 send a frame only when write-data bit 0 is 1. Otherwise they complete at once with no frame.
- R4: Writes to offsets 2 and 21 send write-data bits 7:0 after the opcode. Erase writes (4, 5) send bits 23:0 as 3 address bytes. After an offset-19 command they send bits 31:0 as 4 bytes. After an offset-20 command they return to 3 bytes.
- R5: The 16-bit non-volatile configuration value moves least significant byte first, both when written (offset 13) and when read (offset 14).
- R6: A read of offset 22 clocks in three reply bytes and returns the third byte in bits 7:0.
- R7: An access to any offset without an operation in that direction completes with `csr_wait` low, sends no frame, and reads as 0. This covers reserved offsets, reads of write-only offsets and writes to read-only offsets.
- R8: Offset 8 holds a chip number in bits 7:4 and a release bit in bit 0, and reads back those bits. A frame drives low only `flash_cs_n[n]` for the chosen chip n, and never more than one chip select.
- R9: When control bit 0 is 1, `flash_oe` is low, so the pad drivers release every flash output. Commands still complete on the slave side.
- R10: The serial clock runs at half the system clock and idles low. Bits go MSB first. `flash_mosi` changes only while `flash_sck` is low. The chip select stays low for the whole frame.
- R11: An active-low asynchronous reset clears the control register, selects chip 0, returns to 3-byte addressing, aborts any frame, deasserts all chip selects, and drives `flash_oe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 6 | Register word offset |
| csr_rd | input | 1 | Read strobe, held until waitrequest is low |
| csr_wr | input | 1 | Write strobe, held until waitrequest is low |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid with csr_rvalid |
| csr_wait | output | 1 | Waitrequest |
| csr_rvalid | output | 1 | Read data valid pulse |
| flash_cs_n | output | NCS | Active-low chip selects |
| flash_sck | output | 1 | Serial clock |
| flash_mosi | output | 1 | Serial data to flash |
| flash_miso | input | 1 | Serial data from flash |
| flash_oe | output | 1 | Pad output enable for all flash outputs |

## Verification
The bench attacks the following corner cases, and names what a faulty design would do in each:
- Operand sizing across the 4-byte mode transitions, including a reset taken while the flash is in 4-byte mode. A design that drops or keeps the mode at the wrong moment sends erase frames that are 8 bits off.
- Gated trigger offsets written with bit 0 clear. A missing gate shows up as a spurious frame and a stalled waitrequest.
- Byte ordering of the configuration value and selection of the third identification byte. A swap error returns the two bytes reversed. A wrong byte choice returns the first ID byte.
- Chip-select steering and bus release, plus a reset in the middle of a frame. A leaking select, or a frame that keeps running, is visible at the pins.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int OPC_W  = 8;
    localparam int TX_W   = OPC_W + DATA_W;
    localparam int CNT_W  = $clog2(TX_W + 1);
    localparam int RX_W   = 16;
    localparam int SEL_W  = 4;

    // Register offsets (software-visible decode)
    localparam logic [ADDR_W-1:0] OFF_WREN  = 6'd0;
    localparam logic [ADDR_W-1:0] OFF_WRDI  = 6'd1;
    localparam logic [ADDR_W-1:0] OFF_WRSR  = 6'd2;
    localparam logic [ADDR_W-1:0] OFF_RDSR  = 6'd3;
    localparam logic [ADDR_W-1:0] OFF_SERA  = 6'd4;
    localparam logic [ADDR_W-1:0] OFF_SSERA = 6'd5;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'd8;
    localparam logic [ADDR_W-1:0] OFF_WNVC  = 6'd13;
    localparam logic [ADDR_W-1:0] OFF_RNVC  = 6'd14;
    localparam logic [ADDR_W-1:0] OFF_RFLG  = 6'd15;
    localparam logic [ADDR_W-1:0] OFF_CFLG  = 6'd16;
    localparam logic [ADDR_W-1:0] OFF_CHIP  = 6'd17;
    localparam logic [ADDR_W-1:0] OFF_DIE   = 6'd18;
    localparam logic [ADDR_W-1:0] OFF_A4ON  = 6'd19;
    localparam logic [ADDR_W-1:0] OFF_A4OFF = 6'd20;
    localparam logic [ADDR_W-1:0] OFF_PROT  = 6'd21;
    localparam logic [ADDR_W-1:0] OFF_RID   = 6'd22;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } fsm_e;

    typedef struct packed {
        logic              valid;
        logic [OPC_W-1:0]  op;
        logic [DATA_W-1:0] opnd;   // left aligned
        logic [CNT_W-1:0]  nbits;  // total frame bits
        logic              swap;   // 16-bit reply, LSB byte first
        logic              set4;
        logic              clr4;
    } cmd_t;

endpackage

// File: rtl/sfc_decode.sv
`timescale 1ns/1ps
module sfc_decode
    import sfc_pkg::*;
(
    input  logic [ADDR_W-1:0] off,
    input  logic              is_rd,
    input  logic              is_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              addr4,
    output cmd_t              cmd
);

    logic [CNT_W-1:0] tx_bits;
    logic [CNT_W-1:0] rx_bits;

    always_comb begin
        cmd     = '0;
        tx_bits = '0;
        rx_bits = '0;
        if (is_wr) begin
            case (off)
                OFF_WREN: begin
                    cmd.valid = wdata[0];
                    cmd.op    = 8'h06;
                end
                OFF_WRDI: begin
                    cmd.valid = wdata[0];
                    cmd.op    = 8'h04;
                end
                OFF_WRSR, OFF_PROT: begin
                    cmd.valid = 1'b1;
                    cmd.op    = 8'h01;
                    cmd.opnd  = {wdata[7:0], 24'h0};
                    tx_bits   = CNT_W'(8);
                end
                OFF_SERA, OFF_SSERA: begin
                    cmd.valid = 1'b1;
                    cmd.op    = (off == OFF_SERA) ? 8'hD8 : 8'h20;
                    cmd.opnd  = addr4 ? wdata : {wdata[23:0], 8'h0};
                    tx_bits   = addr4 ? CNT_W'(32) : CNT_W'(24);
                end
                OFF_WNVC: begin
                    cmd.valid = 1'b1;
                    cmd.op    = 8'hB1;
                    cmd.opnd  = {wdata[7:0], wdata[15:8], 16'h0};
                    tx_bits   = CNT_W'(16);
                end
                OFF_CFLG: begin
                    cmd.valid = 1'b1;
                    cmd.op    = 8'h50;
                end
                OFF_CHIP: begin
                    cmd.valid = wdata[0];
                    cmd.op    = 8'hC7;
                end
                OFF_DIE: begin
                    cmd.valid = wdata[0];
                    cmd.op    = 8'hC4;
                end
                OFF_A4ON: begin
                    cmd.valid = wdata[0];
                    cmd.op    = 8'hB7;
                    cmd.set4  = 1'b1;
                end
                OFF_A4OFF: begin
                    cmd.valid = wdata[0];
                    cmd.op    = 8'hE9;
                    cmd.clr4  = 1'b1;
                end
                default: cmd = '0;
            endcase
        end else if (is_rd) begin
            case (off)
                OFF_RDSR: begin
                    cmd.valid = 1'b1;
                    cmd.op    = 8'h05;
                    rx_bits   = CNT_W'(8);
                end
                OFF_RNVC: begin
                    cmd.valid = 1'b1;
                    cmd.op    = 8'hB5;
                    cmd.swap  = 1'b1;
                    rx_bits   = CNT_W'(16);
                end
                OFF_RFLG: begin
                    cmd.valid = 1'b1;
                    cmd.op    = 8'h70;
                    rx_bits   = CNT_W'(8);
                end
                OFF_RID: begin
                    cmd.valid = 1'b1;
                    cmd.op    = 8'h9F;
                    rx_bits   = CNT_W'(24);
                end
                default: cmd = '0;
            endcase
        end
        cmd.nbits = CNT_W'(OPC_W) + tx_bits + rx_bits;
    end

endmodule

// File: rtl/sfc_shift.sv
`timescale 1ns/1ps
module sfc_shift
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TX_W-1:0]  tx_data,
    input  logic [CNT_W-1:0] nbits,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             sck,
    output logic             mosi,
    output logic [RX_W-1:0]  rx
);

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [TX_W-1:0]  tx;
        logic [RX_W-1:0]  rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.busy) begin
            if (start) begin
                sh_d.busy = 1'b1;
                sh_d.sck  = 1'b0;
                sh_d.tx   = tx_data;
                sh_d.cnt  = nbits;
            end
        end else if (!sh_q.sck) begin
            // rising edge: capture reply bit
            sh_d.sck = 1'b1;
            sh_d.rx  = {sh_q.rx[RX_W-2:0], miso};
        end else begin
            // falling edge: present next bit
            sh_d.sck = 1'b0;
            sh_d.tx  = {sh_q.tx[TX_W-2:0], 1'b0};
            if (sh_q.cnt == CNT_W'(1)) begin
                sh_d.busy = 1'b0;
                sh_d.done = 1'b1;
            end else begin
                sh_d.cnt = sh_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign busy = sh_q.busy;
    assign done = sh_q.done;
    assign sck  = sh_q.sck;
    assign mosi = sh_q.tx[TX_W-1];
    assign rx   = sh_q.rx;

endmodule

// File: rtl/sfc_cmd_engine.sv
`timescale 1ns/1ps
module sfc_cmd_engine
    import sfc_pkg::*;
#(
    parameter int NCS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        csr_addr,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              csr_wait,
    output logic              csr_rvalid,
    output logic [NCS-1:0]    flash_cs_n,
    output logic              flash_sck,
    output logic              flash_mosi,
    input  logic              flash_miso,
    output logic              flash_oe
);

    typedef struct packed {
        fsm_e              fsm;
        logic [SEL_W-1:0]  sel;
        logic              rel;
        logic              addr4;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t top_d, top_q;

    logic             is_rd, is_wr, req;
    cmd_t             cmd;
    logic             start;
    logic             wait_c;
    logic             shift_busy, shift_done, sck_int, mosi_int;
    logic [RX_W-1:0]  rx;
    logic [NCS-1:0]   cs_int;
    logic [DATA_W-1:0] result;

    assign is_rd = csr_rd;
    assign is_wr = csr_wr & ~csr_rd;
    assign req   = csr_rd | csr_wr;

    sfc_decode u_dec (
        .off   (csr_addr),
        .is_rd (is_rd),
        .is_wr (is_wr),
        .wdata (csr_wdata),
        .addr4 (top_q.addr4),
        .cmd   (cmd)
    );

    sfc_shift u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_data ({cmd.op, cmd.opnd}),
        .nbits   (cmd.nbits),
        .miso    (flash_miso),
        .busy    (shift_busy),
        .done    (shift_done),
        .sck     (sck_int),
        .mosi    (mosi_int),
        .rx      (rx)
    );

    assign result = cmd.swap ? {16'h0, rx[7:0], rx[15:8]} : {24'h0, rx[7:0]};

    always_comb begin
        top_d        = top_q;
        top_d.rvalid = 1'b0;
        start        = 1'b0;
        wait_c       = 1'b0;
        case (top_q.fsm)
            ST_IDLE: begin
                if (req) begin
                    if (cmd.valid) begin
                        start     = 1'b1;
                        wait_c    = 1'b1;
                        top_d.fsm = ST_RUN;
                    end else begin
                        top_d.rvalid = is_rd;
                        top_d.rdata  = '0;
                        if (csr_addr == OFF_CTRL) begin
                            if (is_rd)
                                top_d.rdata = {24'h0, top_q.sel, 3'b000, top_q.rel};
                            if (is_wr) begin
                                top_d.sel = csr_wdata[7:4];
                                top_d.rel = csr_wdata[0];
                            end
                        end
                    end
                end
            end
            ST_RUN: begin
                wait_c = 1'b1;
                if (shift_done) top_d.fsm = ST_FIN;
            end
            ST_FIN: begin
                top_d.fsm    = ST_IDLE;
                top_d.rvalid = is_rd;
                top_d.rdata  = is_rd ? result : '0;
                if (cmd.set4) top_d.addr4 = 1'b1;
                if (cmd.clr4) top_d.addr4 = 1'b0;
            end
            default: top_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q     <= '0;
            top_q.fsm <= ST_IDLE;
        end else begin
            top_q <= top_d;
        end
    end

    for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
        assign cs_int[gi] = ~(shift_busy && (top_q.sel == SEL_W'(gi)));
    end

    assign flash_cs_n = cs_int;
    assign flash_sck  = sck_int;
    assign flash_mosi = mosi_int;
    assign flash_oe   = ~top_q.rel;
    assign csr_wait   = wait_c;
    assign csr_rvalid = top_q.rvalid;
    assign csr_rdata  = top_q.rdata;

endmodule

// File: rtl/sfc_cmd_checker.sv
`timescale 1ns/1ps
module sfc_cmd_checker #(
    parameter int NCS = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           csr_rd,
    input logic           csr_wr,
    input logic           csr_wait,
    input logic           csr_rvalid,
    input logic           busy,
    input logic           sck_int,
    input logic           mosi_int,
    input logic [NCS-1:0] cs_int
);

    assert_idle_no_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_rd || csr_wr) |-> !csr_wait);

    assert_rvalid_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rvalid |-> $past(csr_rd && !csr_wait));

    assert_wait_during_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> csr_wait);

    assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_int));

    assert_select_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_int));

    assert_sck_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_int);

    assert_mosi_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_int) |-> !sck_int);

endmodule

bind sfc_cmd_engine sfc_cmd_checker #(.NCS(NCS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_rd     (csr_rd),
    .csr_wr     (csr_wr),
    .csr_wait   (csr_wait),
    .csr_rvalid (csr_rvalid),
    .busy       (shift_busy),
    .sck_int    (sck_int),
    .mosi_int   (mosi_int),
    .cs_int     (cs_int)
);

// File: tb/tb_sfc_cmd_engine.sv
`timescale 1ns/1ps
module tb_sfc_cmd_engine;

    localparam int NCS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  csr_addr = '0;
    logic        csr_rd = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_wait, csr_rvalid;
    logic [NCS-1:0] flash_cs_n;
    logic        flash_sck, flash_mosi, flash_oe;
    logic        flash_miso = 1'b0;

    always #2 clk = ~clk;

    sfc_cmd_engine #(.NCS(NCS)) dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_wait(csr_wait), .csr_rvalid(csr_rvalid), .flash_cs_n(flash_cs_n),
        .flash_sck(flash_sck), .flash_mosi(flash_mosi), .flash_miso(flash_miso),
        .flash_oe(flash_oe)
    );

    int nchk = 0;
    int nfail = 0;

    // ---------------- flash model ----------------
    wire sck_b  = flash_oe & flash_sck;
    wire any_cs = flash_oe & ~(&flash_cs_n);
    logic [63:0] cap, last_cap;
    logic [31:0] resp = '0;
    logic [NCS-1:0] cs_seen;
    int  nb = 0, last_nb = 0, frames = 0, per_bad = 0, mosi_bad = 0;
    longint last_rise = 0;
    logic prev_mosi = 1'b0;

    always @(posedge any_cs) begin
        cap = '0;
        nb  = 0;
    end
    always @(posedge sck_b) begin
        cap = {cap[62:0], flash_mosi};
        nb  = nb + 1;
        cs_seen = flash_cs_n;
        if (nb > 1 && ($time - last_rise) != 8) per_bad++;
        last_rise = $time;
    end
    always @(negedge sck_b) begin
        if (nb >= 8 && nb < 40) flash_miso <= resp[31 - (nb - 8)];
    end
    always @(negedge any_cs) begin
        frames++;
        last_nb  = nb;
        last_cap = cap;
    end
    always @(negedge clk) begin
        if (rst_n && flash_sck && (flash_mosi !== prev_mosi)) mosi_bad++;
        prev_mosi = flash_mosi;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [5:0] off, input logic [31:0] wd,
                          output logic [31:0] rd, output int waits, output logic rv);
        @(negedge clk);
        csr_addr = off; csr_wdata = wd; csr_wr = wr; csr_rd = ~wr;
        #1;
        waits = 0;
        while (csr_wait) begin
            @(negedge clk);
            #1;
            waits++;
        end
        @(negedge clk);
        csr_wr = 1'b0; csr_rd = 1'b0;
        rv = csr_rvalid;
        rd = csr_rdata;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    endtask

    // ---------------- stimulus table ----------------
    typedef struct packed {
        logic        wr;
        logic [5:0]  off;
        logic [31:0] wd;
        logic [31:0] resp;
        logic [5:0]  nbits;   // 0: no frame expected
        logic [39:0] frame;
        logic [31:0] rdat;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'd0,  32'h1,        32'h0,        6'd8,  40'h06,         32'h0,    4'd2},  // R2 R3
        '{1'b1, 6'd0,  32'h0,        32'h0,        6'd0,  40'h0,          32'h0,    4'd3},  // R3
        '{1'b1, 6'd1,  32'h1,        32'h0,        6'd8,  40'h04,         32'h0,    4'd2},
        '{1'b1, 6'd1,  32'hFFFFFFFE, 32'h0,        6'd0,  40'h0,          32'h0,    4'd3},
        '{1'b1, 6'd2,  32'h1A5,      32'h0,        6'd16, 40'h01A5,       32'h0,    4'd4},  // R4
        '{1'b0, 6'd3,  32'h0,        32'h5C000000, 6'd16, 40'h0500,       32'h5C,   4'd1},  // R1
        '{1'b1, 6'd4,  32'h12345678, 32'h0,        6'd32, 40'hD8345678,   32'h0,    4'd11}, // R11 3-byte default
        '{1'b1, 6'd5,  32'hABCDEF01, 32'h0,        6'd32, 40'h20CDEF01,   32'h0,    4'd2},
        '{1'b1, 6'd13, 32'h8FFF,     32'h0,        6'd24, 40'hB1FF8F,     32'h0,    4'd5},  // R5
        '{1'b0, 6'd14, 32'h0,        32'hEE8F0000, 6'd24, 40'hB50000,     32'h8FEE, 4'd5},
        '{1'b0, 6'd15, 32'h0,        32'h80000000, 6'd16, 40'h7000,       32'h80,   4'd2},
        '{1'b1, 6'd16, 32'h0,        32'h0,        6'd8,  40'h50,         32'h0,    4'd2},
        '{1'b1, 6'd17, 32'h1,        32'h0,        6'd8,  40'hC7,         32'h0,    4'd2},
        '{1'b1, 6'd17, 32'h0,        32'h0,        6'd0,  40'h0,          32'h0,    4'd3},
        '{1'b1, 6'd18, 32'h1,        32'h0,        6'd8,  40'hC4,         32'h0,    4'd2},
        '{1'b1, 6'd21, 32'h60,       32'h0,        6'd16, 40'h0160,       32'h0,    4'd4},
        '{1'b0, 6'd22, 32'h0,        32'h20BA1800, 6'd32, 40'h9F000000,   32'h18,   4'd6},  // R6
        '{1'b0, 6'd7,  32'h0,        32'h0,        6'd0,  40'h0,          32'h0,    4'd7},  // R7
        '{1'b1, 6'd9,  32'hFFFFFFFF, 32'h0,        6'd0,  40'h0,          32'h0,    4'd7},
        '{1'b0, 6'd0,  32'h0,        32'h0,        6'd0,  40'h0,          32'h0,    4'd7},
        '{1'b1, 6'd3,  32'hFF,       32'h0,        6'd0,  40'h0,          32'h0,    4'd7},
        '{1'b1, 6'd19, 32'h1,        32'h0,        6'd8,  40'hB7,         32'h0,    4'd4},
        '{1'b1, 6'd4,  32'h12345678, 32'h0,        6'd40, 40'hD812345678, 32'h0,    4'd4},
        '{1'b1, 6'd19, 32'h0,        32'h0,        6'd0,  40'h0,          32'h0,    4'd3},
        '{1'b1, 6'd20, 32'h1,        32'h0,        6'd8,  40'hE9,         32'h0,    4'd4},
        '{1'b1, 6'd4,  32'h12345678, 32'h0,        6'd32, 40'hD8345678,   32'h0,    4'd4},
        '{1'b1, 6'd20, 32'h0,        32'h0,        6'd0,  40'h0,          32'h0,    4'd3}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int w, f0;
        logic rv;
        string rq;

        repeat (3) @(negedge clk);
        // R11: reset state at the pins
        chk("R11", "cs_n in reset", 64'(flash_cs_n), 64'(3'b111));
        chk("R11", "sck in reset", 64'(flash_sck), 64'h0);
        chk("R11", "oe in reset", 64'(flash_oe), 64'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "wait idle", 64'(csr_wait), 64'h0);
        chk("R11", "rvalid idle", 64'(csr_rvalid), 64'h0);
        access(1'b0, 6'd8, 32'h0, rd, w, rv);
        chk("R11", "control after reset", 64'(rd), 64'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            rq = $sformatf("R%0d", VECS[i].rq);
            resp = VECS[i].resp;
            f0 = frames;
            access(VECS[i].wr, VECS[i].off, VECS[i].wd, rd, w, rv);
            if (VECS[i].nbits == 0) begin
                chk(rq, $sformatf("v%0d no frame", i), 64'(frames - f0), 64'h0);
                chk(rq, $sformatf("v%0d immediate", i), 64'(w), 64'h0);
            end else begin
                chk(rq, $sformatf("v%0d one frame", i), 64'(frames - f0), 64'h1);
                chk(rq, $sformatf("v%0d bit count", i), 64'(last_nb), 64'(VECS[i].nbits));
                chk(rq, $sformatf("v%0d frame bits", i), last_cap & ((64'h1 << VECS[i].nbits) - 1), 64'(VECS[i].frame));
                chk("R1", $sformatf("v%0d wait held", i), 64'(w >= 2 * int'(VECS[i].nbits)), 64'h1);
                chk("R8", $sformatf("v%0d chip 0", i), 64'(cs_seen), 64'(3'b110));
            end
            chk("R1", $sformatf("v%0d rvalid", i), 64'(rv), 64'(!VECS[i].wr));
            if (!VECS[i].wr) chk(rq, $sformatf("v%0d rdata", i), 64'(rd), 64'(VECS[i].rdat));
        end
        resp = '0;

        // R8: chip steering and readback
        access(1'b1, 6'd8, 32'h10, rd, w, rv);
        access(1'b0, 6'd8, 32'h0, rd, w, rv);
        chk("R8", "control readback", 64'(rd), 64'h10);
        access(1'b1, 6'd0, 32'h1, rd, w, rv);
        chk("R8", "chip 1 select", 64'(cs_seen), 64'(3'b101));
        access(1'b1, 6'd8, 32'h20, rd, w, rv);
        access(1'b1, 6'd17, 32'h1, rd, w, rv);
        chk("R8", "chip 2 select", 64'(cs_seen), 64'(3'b011));
        chk("R8", "chip 2 frame", last_cap & 64'hFF, 64'hC7);

        // R9: bus release
        access(1'b1, 6'd8, 32'h01, rd, w, rv);
        chk("R9", "oe low", 64'(flash_oe), 64'h0);
        f0 = frames;
        access(1'b1, 6'd0, 32'h1, rd, w, rv);
        chk("R9", "no visible frame", 64'(frames - f0), 64'h0);
        chk("R9", "command still completes", 64'(w >= 16), 64'h1);
        access(1'b0, 6'd8, 32'h0, rd, w, rv);
        chk("R9", "release readback", 64'(rd), 64'h1);
        access(1'b1, 6'd8, 32'h00, rd, w, rv);
        chk("R9", "oe back high", 64'(flash_oe), 64'h1);

        // R11: reset mid-frame while in 4-byte mode
        access(1'b1, 6'd19, 32'h1, rd, w, rv);
        @(negedge clk);
        csr_addr = 6'd17; csr_wdata = 32'h1; csr_wr = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b0; csr_wr = 1'b0;
        #1;
        chk("R11", "cs released by reset", 64'(flash_cs_n), 64'(3'b111));
        chk("R11", "sck low in reset", 64'(flash_sck), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b1, 6'd4, 32'h12345678, rd, w, rv);
        chk("R11", "3-byte after reset", 64'(last_nb), 64'd32);
        chk("R11", "erase frame after reset", last_cap & 64'hFFFFFFFF, 64'hD8345678);

        // R10: serial timing
        chk("R10", "sck period", 64'(per_bad), 64'h0);
        chk("R10", "mosi stable while sck high", 64'(mosi_bad), 64'h0);

        summary();
        $finish;
    end

endmodule